// File: doc/BRIEF.md
# Four-Lane TDM Audio Serializer

The block turns 24-bit channel samples into a time-division multiplexed serial stream on four data lanes. It makes its own bit clock, frame clock and master clock from the system clock. One frame always lasts 1024 system cycles. The master clock toggles every two system cycles. The bit clock rate depends on the lane mode, which selects 16, 8, 4 or 2 channels per lane. Each channel occupies a 32-bit slot: the 24 audio bits come first, most significant bit first, and 8 zero bits follow. In left-justified format the first slot starts with the frame. In I2S format the whole frame is shifted one bit period later.

A producer watches the one-cycle frame-start pulse. It writes the samples for the next frame into a pending bank by channel index, then strobes a commit. At the next frame boundary the block swaps banks and plays the committed set. The block raises its mute flag and drives zeros on every lane in three cases: when the boundary arrives with no commit, for the first frame that uses a new mode or format, and while a mute request is held.

Top module: `tdm_tx`

## Requirements
- R1: With lane mode code 0, 1, 2 or 3, the bit clock period is 2, 4, 8 or 16 system cycles. It is low in the first half of each bit period, which gives 512, 256, 128 or 64 bit periods per frame.
- R2: The master clock period is 4 system cycles in every mode: 2 cycles low, then 2 cycles high, starting at the frame start. This gives 256 periods per frame.
- R3: A frame is 1024 system cycles long. The frame clock is low for the first 512 and high for the last 512. `sampleReq` is high for exactly one cycle: the first cycle of each frame, which is when the frame clock falls.
- R4: Lane data changes only in a cycle where the bit clock has just fallen, unless the mute flag changes in that same cycle.
- R5: Each 32-bit slot carries sample bits 23 down to 0 in its first 24 bit periods and zeros in the last 8.
- R6: When `i2sMode` is 1, every lane's bit sequence is delayed by one bit period. The first bit period of the frame then carries the last padding bit of the final slot, which is 0.
- R7: In a mode with K channels per lane, lane n slot j carries the channel with index n*K+j as written through `loadChan` (K = 16, 8, 4, 2 for codes 0 to 3).
- R8: A write with `loadValid` goes to the pending bank. A commit seen in any cycle of a frame, including its last cycle, makes the pending bank play in the next frame. A write in that last cycle is included. Writes never disturb the frame being played.
- R9: If a frame boundary passes with no commit since the previous boundary, the next frame has `muteOut` high and all lanes low for the whole frame.
- R10: `laneMode` and `i2sMode` are taken only at frame boundaries. The first frame played with a changed value has `muteOut` high and all lanes low.
- R11: `muteOut` is high one cycle after `muteReq` is high. All lanes are low whenever `muteOut` is high.
- R12: During reset, the bit clock, frame clock, master clock, lanes and `sampleReq` are low and `muteOut` is high. The first frame after reset uses mode code 0 in left-justified format, and it is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| laneMode | input | 2 | Channels per lane: 0=16, 1=8, 2=4, 3=2 |
| i2sMode | input | 1 | 0 = left-justified, 1 = one-bit delayed |
| loadValid | input | 1 | Write strobe for one sample |
| loadChan | input | 6 | Channel index of the write |
| loadData | input | 24 | Sample value |
| loadCommit | input | 1 | Mark the pending bank ready for the next frame |
| muteReq | input | 1 | Force mute |
| bitClk | output | 1 | Bit clock |
| frameClk | output | 1 | Frame clock, falls at frame start |
| mclkOut | output | 1 | Master clock |
| txData | output | 4 | Serial data lanes |
| muteOut | output | 1 | High when lane data is invalid |
| sampleReq | output | 1 | One-cycle pulse at frame start |

## Verification
A commit strobe can land in the same cycle as the frame-boundary decision, which makes the banks swap and settles the mute for the next frame. The bench provokes this by strobing the commit in the last system cycle of a frame. It then strobes a commit one cycle later, in the first cycle of the next frame. The first case must play the new samples in the next frame. The second case must mute that frame and play the samples one frame later. A mode or format write during a frame is also checked: the frame in progress must keep its old clocks and bit layout.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [1:0] {
    LANE16 = 2'd0,
    LANE8  = 2'd1,
    LANE4  = 2'd2,
    LANE2  = 2'd3
  } laneMode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic      frameHead;  // phase is at the first cycle of a frame
    logic      silence;    // lanes must be muted
    laneMode_e mode;       // mode latched for this frame
    logic      i2sDelay;   // one-bit delayed format for this frame
    logic      rdBank;     // bank being played
  } txCtl_t;

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int PHW = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     modeSel,
  input  logic           i2sSel,
  input  logic           loadCommit,
  input  logic           muteReq,
  output logic [PHW-1:0] phase,
  output txCtl_t         ctl
);

  laneMode_e cfgMode;
  logic      cfgI2s;
  logic      commitPend;
  logic      rdBank;
  logic      frameMute;
  logic      frameEnd;
  logic      swapNow;
  logic      cfgDiffers;

  assign frameEnd   = (phase == {PHW{1'b1}});
  assign swapNow    = commitPend | loadCommit;
  assign cfgDiffers = (laneMode_e'(modeSel) != cfgMode) | (i2sSel != cfgI2s);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= '0;
      cfgMode    <= LANE16;
      cfgI2s     <= 1'b0;
      commitPend <= 1'b0;
      rdBank     <= 1'b0;
      frameMute  <= 1'b1;
    end else begin
      phase <= phase + 1'b1;
      if (frameEnd) begin
        cfgMode    <= laneMode_e'(modeSel);
        cfgI2s     <= i2sSel;
        frameMute  <= cfgDiffers | ~swapNow;
        commitPend <= 1'b0;
        if (swapNow) rdBank <= ~rdBank;
      end else if (loadCommit) begin
        commitPend <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.frameHead = (phase == '0);
    ctl.silence   = frameMute | muteReq;
    ctl.mode      = cfgMode;
    ctl.i2sDelay  = cfgI2s;
    ctl.rdBank    = rdBank;
  end

endmodule

// File: rtl/tdm_tx_store.sv
module tdm_tx_store #(
  parameter int DEPTH = 64,
  parameter int W     = 24,
  parameter int RD    = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rdBank,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [W-1:0]         wrData,
  input  logic [RD-1:0][AW-1:0] rdAddr,
  output logic [RD-1:0][W-1:0]  rdData
);

  logic [W-1:0] mem [2][DEPTH];

  // writes always land in the bank that is not being played
  always_ff @(posedge clk) begin
    if (wrEn) mem[~rdBank][wrAddr] <= wrData;
  end

  for (genvar r = 0; r < RD; r++) begin : gRead
    assign rdData[r] = mem[rdBank][rdAddr[r]];
  end

endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int MAX_CH     = 16,
  parameter int SLOT_BITS  = 32,
  parameter int AUDIO_BITS = 24,
  parameter int PHW        = 10,
  parameter int CHW        = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PHW-1:0]        phase,
  input  txCtl_t                ctl,
  input  logic                  loadValid,
  input  logic [CHW-1:0]        loadChan,
  input  logic [AUDIO_BITS-1:0] loadData,
  output logic                  bitClk,
  output logic                  frameClk,
  output logic                  mclkOut,
  output logic [LINES-1:0]      txData,
  output logic                  muteOut,
  output logic                  sampleReq
);

  localparam int BW         = PHW - 1;
  localparam int SLW        = $clog2(SLOT_BITS);
  localparam int TOTAL_BITS = MAX_CH * SLOT_BITS;
  localparam int CH_TOTAL   = LINES * MAX_CH;

  logic [1:0]     sh;
  logic [BW-1:0]  bitIdx;
  logic [BW-1:0]  bitMask;
  logic [BW-1:0]  effIdx;
  logic [BW-1:0]  slotIdx;
  logic [SLW-1:0] bitPos;
  int             perLine;
  logic           inAudio;

  logic [LINES-1:0][CHW-1:0]        rdIdx;
  logic [LINES-1:0][AUDIO_BITS-1:0] rdData;
  logic [LINES-1:0]                 laneBit;

  assign sh = ctl.mode;

  always_comb begin
    bitIdx  = BW'(phase >> ({1'b0, sh} + 3'd1));
    bitMask = BW'((TOTAL_BITS >> sh) - 1);
    effIdx  = ctl.i2sDelay ? ((bitIdx - BW'(1)) & bitMask) : bitIdx;
    slotIdx = effIdx >> SLW;
    bitPos  = effIdx[SLW-1:0];
    perLine = MAX_CH >> sh;
    inAudio = (int'(bitPos) < AUDIO_BITS);
  end

  for (genvar g = 0; g < LINES; g++) begin : gLane
    logic [AUDIO_BITS-1:0] aligned;
    assign rdIdx[g]   = CHW'(g * perLine + int'(slotIdx));
    assign aligned    = rdData[g] << bitPos;
    assign laneBit[g] = inAudio & aligned[AUDIO_BITS-1];
  end

  tdm_tx_store #(
    .DEPTH(CH_TOTAL),
    .W    (AUDIO_BITS),
    .RD   (LINES),
    .AW   (CHW)
  ) store_i (
    .clk   (clk),
    .rdBank(ctl.rdBank),
    .wrEn  (loadValid),
    .wrAddr(loadChan),
    .wrData(loadData),
    .rdAddr(rdIdx),
    .rdData(rdData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitClk    <= 1'b0;
      frameClk  <= 1'b0;
      mclkOut   <= 1'b0;
      txData    <= '0;
      muteOut   <= 1'b1;
      sampleReq <= 1'b0;
    end else begin
      bitClk    <= phase[sh];
      frameClk  <= phase[PHW-1];
      mclkOut   <= phase[1];
      txData    <= ctl.silence ? '0 : laneBit;
      muteOut   <= ctl.silence;
      sampleReq <= ctl.frameHead;
    end
  end

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int MAX_CH     = 16,
  parameter int SLOT_BITS  = 32,
  parameter int AUDIO_BITS = 24,
  localparam int CHW       = $clog2(LINES * MAX_CH),
  localparam int PHW       = $clog2(2 * MAX_CH * SLOT_BITS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            laneMode,
  input  logic                  i2sMode,
  input  logic                  loadValid,
  input  logic [CHW-1:0]        loadChan,
  input  logic [AUDIO_BITS-1:0] loadData,
  input  logic                  loadCommit,
  input  logic                  muteReq,
  output logic                  bitClk,
  output logic                  frameClk,
  output logic                  mclkOut,
  output logic [LINES-1:0]      txData,
  output logic                  muteOut,
  output logic                  sampleReq
);

  logic [PHW-1:0] phase;
  txCtl_t         ctl;

  tdm_tx_ctrl #(.PHW(PHW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (laneMode),
    .i2sSel    (i2sMode),
    .loadCommit(loadCommit),
    .muteReq   (muteReq),
    .phase     (phase),
    .ctl       (ctl)
  );

  tdm_tx_datapath #(
    .LINES     (LINES),
    .MAX_CH    (MAX_CH),
    .SLOT_BITS (SLOT_BITS),
    .AUDIO_BITS(AUDIO_BITS),
    .PHW       (PHW),
    .CHW       (CHW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .phase    (phase),
    .ctl      (ctl),
    .loadValid(loadValid),
    .loadChan (loadChan),
    .loadData (loadData),
    .bitClk   (bitClk),
    .frameClk (frameClk),
    .mclkOut  (mclkOut),
    .txData   (txData),
    .muteOut  (muteOut),
    .sampleReq(sampleReq)
  );

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             muteReq,
  input logic             bitClk,
  input logic             frameClk,
  input logic             mclkOut,
  input logic [LINES-1:0] txData,
  input logic             muteOut,
  input logic             sampleReq
);

  // R2
  mclk_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mclkOut) |=> mclkOut ##1 !mclkOut);

  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameClk) |-> sampleReq);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq);

  // R3
  req_low_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> !frameClk);

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txData != $past(txData)) && $stable(muteOut)) |-> (!bitClk && $past(bitClk)));

  // R11
  mute_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(muteReq) |-> muteOut);

  // R11
  mute_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    muteOut |-> (txData == '0));

endmodule

bind tdm_tx tdm_tx_chk #(.LINES(LINES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .muteReq  (muteReq),
  .bitClk   (bitClk),
  .frameClk (frameClk),
  .mclkOut  (mclkOut),
  .txData   (txData),
  .muteOut  (muteOut),
  .sampleReq(sampleReq)
);

// File: tb/tdm_tx_tb_top.sv
module tdm_tx_tb_top;

  localparam int LINES = 4;
  localparam int CHT   = 64;
  localparam int AUD   = 24;
  localparam int FRAME = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN = 1'b0;
  logic [1:0]       laneMode = 2'd0;
  logic             i2sMode = 1'b0;
  logic             loadValid = 1'b0;
  logic [5:0]       loadChan = '0;
  logic [AUD-1:0]   loadData = '0;
  logic             loadCommit = 1'b0;
  logic             muteReq = 1'b0;
  logic             bitClk, frameClk, mclkOut, muteOut, sampleReq;
  logic [LINES-1:0] txData;

  tdm_tx dut_i (
    .clk(clk), .rstN(rstN), .laneMode(laneMode), .i2sMode(i2sMode),
    .loadValid(loadValid), .loadChan(loadChan), .loadData(loadData),
    .loadCommit(loadCommit), .muteReq(muteReq),
    .bitClk(bitClk), .frameClk(frameClk), .mclkOut(mclkOut),
    .txData(txData), .muteOut(muteOut), .sampleReq(sampleReq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  int tk = 0;
  bit started = 0;
  int curMode = 0, curFmt = 0;
  bit curMute = 1;
  logic [AUD-1:0] curSamp [CHT];
  logic [AUD-1:0] nxtSamp [CHT];
  logic [AUD-1:0] snapSamp [CHT];
  bit pendModel = 0, snapCommit = 0, haveSnap = 0;
  int snapMode = 0, snapFmt = 0;
  bit prevMuteReq = 0;
  logic [LINES-1:0] prevData = '0;
  bit prevMute = 1, prevB = 0;
  int badB, badM, badF, badD, badMu, badE;

  task automatic report(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [AUD-1:0] pat(int seed, int ch);
    logic [31:0] h;
    h = (32'(seed) * 32'h9E3779B1) ^ (32'(ch + 1) * 32'h85EBCA6B);
    h = h ^ (h >> 13);
    return h[AUD-1:0];
  endfunction

  // expected lane bit from R5, R6, R7
  function automatic bit expBit(int ln);
    int s, bits, k, b, e, slot, bp;
    s = curMode; bits = 512 >> s; k = 16 >> s;
    b = tk >> (s + 1);
    e = (curFmt != 0) ? (b + bits - 1) % bits : b;
    slot = e / 32; bp = e % 32;
    if (bp >= AUD) return 1'b0;
    return curSamp[ln * k + slot][AUD - 1 - bp];
  endfunction

  task automatic finalizeFrame();
    report(tk == FRAME - 1, "R3", "frame length", tk + 1, FRAME);
    report(badB == 0, "R1", "bit clock mismatches", badB, 0);
    report(badM == 0, "R2", "master clock mismatches", badM, 0);
    report(badF == 0, "R3", "frame clock mismatches", badF, 0);
    report(badE == 0, "R4", "data change off bit boundary", badE, 0);
    report(badD == 0, "R5 R6 R7 R8", "lane data mismatches", badD, 0);
    report(badMu == 0, "R9 R10 R11", "mute flag mismatches", badMu, 0);
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (sampleReq) begin
        if (started) finalizeFrame();
        if (haveSnap) begin
          curMute = (snapMode != curMode) || (snapFmt != curFmt) || !snapCommit;
          if (snapCommit) curSamp = snapSamp;
          curMode = snapMode;
          curFmt  = snapFmt;
        end else begin
          curMute = 1;
        end
        haveSnap = 0; started = 1; tk = 0;
        badB = 0; badM = 0; badF = 0; badD = 0; badMu = 0; badE = 0;
      end else begin
        tk++;
      end
      if (started) begin
        bit mExp;
        mExp = curMute | prevMuteReq;
        if (bitClk !== 1'((tk >> curMode) & 1)) badB++;
        if (mclkOut !== 1'((tk >> 1) & 1)) badM++;
        if (frameClk !== (tk >= FRAME / 2)) badF++;
        if (muteOut !== mExp) badMu++;
        for (int ln = 0; ln < LINES; ln++) begin
          bit eb;
          eb = mExp ? 1'b0 : expBit(ln);
          if (txData[ln] !== eb) badD++;
        end
        if ((txData != prevData) && (muteOut == prevMute) && !(!bitClk && prevB)) badE++;
      end
      if (loadValid) nxtSamp[loadChan] = loadData;
      if (loadCommit) pendModel = 1;
      if (started && tk == FRAME - 2) begin
        snapMode = laneMode; snapFmt = i2sMode; snapCommit = pendModel;
        snapSamp = nxtSamp; pendModel = 0; haveSnap = 1;
      end
      prevMuteReq = muteReq;
      prevData = txData; prevMute = muteOut; prevB = bitClk;
    end
  end

  task automatic waitTk(int k);
    do begin
      @(negedge clk); #1;
    end while (!(started && tk == k));
    @(posedge clk); #1;
  endtask

  // commitKind: 0 none, 1 early, 2 last cycle of frame, 3 first cycle of next frame
  task automatic doFrame(int mode, int fmt, int seed, int commitKind, int muteLen);
    waitTk(2);
    laneMode = 2'(mode);
    i2sMode  = 1'(fmt);
    for (int ch = 0; ch < CHT; ch++) begin
      loadValid = 1; loadChan = 6'(ch); loadData = pat(seed, ch);
      @(posedge clk); #1;
    end
    loadValid = 0;
    if (commitKind == 1) begin
      loadCommit = 1; @(posedge clk); #1; loadCommit = 0;
    end
    if (muteLen > 0) begin
      waitTk(300);
      muteReq = 1;
      repeat (muteLen) @(posedge clk);
      #1 muteReq = 0;
    end
    if (commitKind == 2) begin
      waitTk(FRAME - 3);
      loadCommit = 1; @(posedge clk); #1; loadCommit = 0;
    end else if (commitKind == 3) begin
      waitTk(FRAME - 2);
      loadCommit = 1; @(posedge clk); #1; loadCommit = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < CHT; i++) begin
      curSamp[i] = '0; nxtSamp[i] = '0; snapSamp[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    report(bitClk == 0 && frameClk == 0 && mclkOut == 0, "R12", "clocks in reset",
           {bitClk, frameClk, mclkOut}, 0);
    report(txData == 0 && sampleReq == 0, "R12", "data/request in reset",
           {txData, sampleReq}, 0);
    report(muteOut == 1, "R12", "mute in reset", muteOut, 1);
    @(posedge clk); #1 rstN = 1;

    doFrame(0, 0, 1, 1, 0);
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 2; f++) begin
        doFrame(m, f, 10 + m * 4 + f * 2, 1, 0);
        doFrame(m, f, 11 + m * 4 + f * 2, 1, 0);
      end
    end
    doFrame(0, 0, 49, 1, 0);
    doFrame(0, 0, 50, 2, 0);   // R8 commit in last cycle of frame
    doFrame(0, 0, 51, 3, 0);   // R9 commit one cycle too late
    doFrame(0, 0, 52, 0, 0);   // late commit plays here
    doFrame(0, 0, 53, 0, 0);   // R9 starved
    doFrame(0, 0, 54, 1, 0);
    doFrame(0, 0, 55, 1, 40);  // R11 mute request mid-frame
    doFrame(2, 1, 56, 1, 0);   // R10 change while playing
    doFrame(2, 1, 57, 1, 0);
    waitTk(2);
    waitTk(FRAME - 4);
    waitTk(2);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      report(1'b0, "R3", "watchdog expired", 1, 0);
      finishRun();
    end
  end

endmodule